// File: doc/BRIEF.md
# Serial ROM Port with Pin Sharing

This block runs a three-wire serial configuration ROM: select, shift clock and data-out, plus a sampled data-in line. Three sources share the outgoing pins. A word loader reads a fixed number of 16-bit words and hands each one to downstream logic. A software bit-bang mode drives the pins straight from register bits. When neither is active, the clock and data-out pins carry two LED signals and the select pin is held low.

A read runs by itself after hardware reset and again each time software writes the read-request bit. Each word uses one select window. It sends a start bit, a two-bit read opcode and a 6-bit word address, then shifts in 16 data bits. At the end of the read a checksum over all bytes sets or clears a valid flag. A ROM-detect input is sampled when a read starts. If no ROM is fitted, the loader gives up after two shift-clock pulses and clears the flag.

Top module: `srom_port`

## Requirements
- R1: While hardware reset is asserted, the port-enable and select register bits read 0, `checksum_ok` is 0 and `busy` is 1, so a read begins as soon as reset is released.
- R2: When idle with port-enable 1, `rom_cs`, `rom_sk` and `rom_do` equal the select, clock and data register bits. A register write sampled at a clock edge shows on the pins straight after that edge.
- R3: When idle with port-enable 0, `rom_cs` is 0 whatever the select bit holds, `rom_sk` follows `led_sk` and `rom_do` follows `led_do`.
- R4: A read drives the pins for the whole read. It begins with one launch cycle with all pins low. Each word then takes 26 bit periods of 2*DIV clocks each, and `rom_sk` is low for the first DIV clocks of every period and high for the rest. `rom_cs` is high for periods 0 to 24 and low in period 25. In periods 0 to 8, `rom_do` carries 1, 1, 0 followed by the word index as a 6-bit address, MSB first. Words are read at indices 0 to NUM_WORDS-1.
- R5: `rom_di` is sampled in the last clock of the high half of periods 9 to 24, MSB first. The word is presented on `ld_data` with its index on `ld_addr` while `ld_we` is high for the first clock of period 25.
- R6: If `rom_detect` is 0 at launch, only two `rom_sk` pulses appear. `busy` drops after the launch cycle plus 4*DIV clocks, no word is delivered and `checksum_ok` is cleared.
- R7: If `rom_detect` is 1 at launch, all words are read. When `busy` drops, `checksum_ok` becomes 1 exactly when the sum of every byte of every word, modulo 256, is 0xFF. Otherwise it becomes 0, and it holds its value while idle.
- R8: A write with `cfg_read` set while idle starts a read whatever port-enable holds. `busy` is high from the next cycle until the read ends (1 + NUM_WORDS*52*DIV cycles for a full read), then reads 0 again. A request made while busy is ignored.
- R9: Register writes during a read update the bits without reaching the pins. The new values take over the pins once `busy` drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Hardware reset, active low, asynchronous assert |
| cfg_we | input | 1 | Register write strobe |
| cfg_port_en | input | 1 | Port-enable bit value to write |
| cfg_cs | input | 1 | Select bit value to write |
| cfg_sk | input | 1 | Clock bit value to write |
| cfg_do | input | 1 | Data-out bit value to write |
| cfg_read | input | 1 | Read request (acts when written as 1) |
| led_sk | input | 1 | LED signal shown on the clock pin when idle and disabled |
| led_do | input | 1 | LED signal shown on the data-out pin when idle and disabled |
| rom_detect | input | 1 | High when a ROM is fitted |
| rom_di | input | 1 | Serial data from the ROM |
| rom_cs | output | 1 | ROM select |
| rom_sk | output | 1 | ROM shift clock |
| rom_do | output | 1 | Serial data to the ROM |
| port_en | output | 1 | Port-enable bit readback |
| cs_bit | output | 1 | Select bit readback |
| busy | output | 1 | Read in progress (doubles as the self-clearing request bit) |
| checksum_ok | output | 1 | Result of the last completed or aborted read |
| ld_we | output | 1 | One-cycle strobe for a loaded word |
| ld_addr | output | ADDR_W | Index of the loaded word |
| ld_data | output | DATA_W | Loaded word |

## Verification
The bench aims at the boundaries between pin owners. A mux that gave bit-bang priority over the loader would show register values on the pins in the middle of a read. One that let the select bit through while disabled would raise `rom_cs` with port-enable 0. The abort path is checked by counting clock pulses and busy cycles with detect low. An off-by-one abort would give one or three pulses, and a missed clear would leave the earlier pass flag standing. Reads are run with a passing checksum, then with one byte changed, then with it passing again. This catches a flag that never toggles, a sum that leaves out the last word, and a sample point one phase off, which would put shifted data on `ld_data`.

// File: rtl/srom_pkg.sv
package srom_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LAUNCH = 2'd1,
    ST_RUN    = 2'd2
  } srom_st_e;

  // start bit followed by read opcode
  localparam logic [2:0] CMD_HEAD = 3'b110;
endpackage

// File: rtl/srom_tick.sv
module srom_tick #(
  parameter int DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt, cnt_n;

  always_comb begin
    tick  = en && (cnt == LAST);
    cnt_n = cnt;
    if (!en || tick) cnt_n = '0;
    else             cnt_n = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_n;
  end
endmodule

// File: rtl/srom_regs.sv
module srom_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic we,
  input  logic d_en,
  input  logic d_cs,
  input  logic d_sk,
  input  logic d_do,
  output logic q_en,
  output logic q_cs,
  output logic q_sk,
  output logic q_do
);
  logic en_n, cs_n, sk_n, do_n;

  always_comb begin
    en_n = q_en;
    cs_n = q_cs;
    sk_n = q_sk;
    do_n = q_do;
    if (we) begin
      en_n = d_en;
      cs_n = d_cs;
      sk_n = d_sk;
      do_n = d_do;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_en <= 1'b0;
      q_cs <= 1'b0;
      q_sk <= 1'b0;
      q_do <= 1'b0;
    end else begin
      q_en <= en_n;
      q_cs <= cs_n;
      q_sk <= sk_n;
      q_do <= do_n;
    end
  end
endmodule

// File: rtl/srom_seq.sv
module srom_seq
  import srom_pkg::*;
#(
  parameter int NUM_WORDS = 8,
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              detect,
  input  logic              ser_di,
  input  logic              tick,
  output logic              run,
  output logic              busy,
  output logic              seq_cs,
  output logic              seq_sk,
  output logic              seq_do,
  output logic              valid,
  output logic              ld_we,
  output logic [ADDR_W-1:0] ld_addr,
  output logic [DATA_W-1:0] ld_data
);
  localparam int CMD_BITS = 3 + ADDR_W;
  localparam int GAP      = CMD_BITS + DATA_W;
  localparam int SLOT_W   = $clog2(GAP + 1);
  localparam int WORD_W   = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam int ABORT_AT = 1;
  localparam logic [SLOT_W-1:0] GAP_S   = SLOT_W'(GAP);
  localparam logic [SLOT_W-1:0] LDAT_S  = SLOT_W'(GAP - 1);
  localparam logic [SLOT_W-1:0] CMD_S   = SLOT_W'(CMD_BITS);
  localparam logic [SLOT_W-1:0] ABORT_S = SLOT_W'(ABORT_AT);
  localparam logic [WORD_W-1:0] LAST_W  = WORD_W'(NUM_WORDS - 1);

  function automatic logic [7:0] byte_sum(input logic [DATA_W-1:0] w);
    logic [7:0] s;
    s = '0;
    for (int b = 0; b < DATA_W / 8; b++) s = s + w[b*8 +: 8];
    return s;
  endfunction

  srom_st_e          st, st_n;
  logic              phase, phase_n;
  logic [SLOT_W-1:0] slot, slot_n;
  logic [WORD_W-1:0] word, word_n;
  logic              absent, absent_n;
  logic [DATA_W-1:0] shreg, shreg_n, word_in;
  logic [7:0]        sum, sum_n;
  logic              valid_n, ld_we_n;
  logic [ADDR_W-1:0] ld_addr_n;
  logic [DATA_W-1:0] ld_data_n;
  logic [CMD_BITS-1:0] cmd_vec, cmd_sh;

  // next-state
  always_comb begin
    st_n      = st;
    phase_n   = phase;
    slot_n    = slot;
    word_n    = word;
    absent_n  = absent;
    shreg_n   = shreg;
    sum_n     = sum;
    valid_n   = valid;
    ld_we_n   = 1'b0;
    ld_addr_n = ld_addr;
    ld_data_n = ld_data;
    word_in   = {shreg[DATA_W-2:0], ser_di};
    case (st)
      ST_IDLE: begin
        if (start) st_n = ST_LAUNCH;
      end
      ST_LAUNCH: begin
        phase_n  = 1'b0;
        slot_n   = '0;
        word_n   = '0;
        sum_n    = '0;
        absent_n = ~detect;
        st_n     = ST_RUN;
      end
      ST_RUN: begin
        if (tick) begin
          if (!phase) begin
            phase_n = 1'b1;
          end else begin
            phase_n = 1'b0;
            if (absent && slot == ABORT_S) begin
              st_n    = ST_IDLE;
              valid_n = 1'b0;
            end else if (slot == GAP_S) begin
              slot_n = '0;
              if (word == LAST_W) begin
                st_n    = ST_IDLE;
                valid_n = (sum == 8'hFF);
              end else begin
                word_n = word + 1'b1;
              end
            end else begin
              if (slot >= CMD_S) shreg_n = word_in;
              if (slot == LDAT_S) begin
                ld_we_n   = 1'b1;
                ld_addr_n = ADDR_W'(word);
                ld_data_n = word_in;
                sum_n     = sum + byte_sum(word_in);
              end
              slot_n = slot + 1'b1;
            end
          end
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_LAUNCH;
      phase   <= 1'b0;
      slot    <= '0;
      word    <= '0;
      absent  <= 1'b0;
      shreg   <= '0;
      sum     <= '0;
      valid   <= 1'b0;
      ld_we   <= 1'b0;
      ld_addr <= '0;
      ld_data <= '0;
    end else begin
      st      <= st_n;
      phase   <= phase_n;
      slot    <= slot_n;
      word    <= word_n;
      absent  <= absent_n;
      shreg   <= shreg_n;
      sum     <= sum_n;
      valid   <= valid_n;
      ld_we   <= ld_we_n;
      ld_addr <= ld_addr_n;
      ld_data <= ld_data_n;
    end
  end

  // pin drive while reading
  always_comb begin
    run     = (st == ST_RUN);
    busy    = (st != ST_IDLE);
    cmd_vec = {CMD_HEAD, ADDR_W'(word)};
    cmd_sh  = cmd_vec << slot;
    seq_cs  = run && (slot != GAP_S);
    seq_sk  = seq_cs && phase;
    seq_do  = run && (slot < CMD_S) && cmd_sh[CMD_BITS-1];
  end

  AST_ABORT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && absent) |-> (slot < SLOT_W'(2))); // R6
  AST_NO_LOAD_ABSENT: assert property (@(posedge clk) disable iff (!rst_n)
    ld_we |-> !absent); // R6
  AST_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN) |-> (slot <= GAP_S)); // R4
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && $past(st) == ST_IDLE) |-> $stable(valid)); // R7
endmodule

// File: rtl/srom_pinmux.sv
module srom_pinmux (
  input  logic busy,
  input  logic r_en,
  input  logic r_cs,
  input  logic r_sk,
  input  logic r_do,
  input  logic led_sk,
  input  logic led_do,
  input  logic s_cs,
  input  logic s_sk,
  input  logic s_do,
  output logic p_cs,
  output logic p_sk,
  output logic p_do
);
  always_comb begin
    if (busy) begin
      p_cs = s_cs;
      p_sk = s_sk;
      p_do = s_do;
    end else if (r_en) begin
      p_cs = r_cs;
      p_sk = r_sk;
      p_do = r_do;
    end else begin
      p_cs = 1'b0;
      p_sk = led_sk;
      p_do = led_do;
    end
  end
endmodule

// File: rtl/srom_port.sv
module srom_port #(
  parameter int DIV       = 2,
  parameter int NUM_WORDS = 8,
  parameter int ADDR_W    = 6,
  parameter int DATA_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_port_en,
  input  logic              cfg_cs,
  input  logic              cfg_sk,
  input  logic              cfg_do,
  input  logic              cfg_read,
  input  logic              led_sk,
  input  logic              led_do,
  input  logic              rom_detect,
  input  logic              rom_di,
  output logic              rom_cs,
  output logic              rom_sk,
  output logic              rom_do,
  output logic              port_en,
  output logic              cs_bit,
  output logic              busy,
  output logic              checksum_ok,
  output logic              ld_we,
  output logic [ADDR_W-1:0] ld_addr,
  output logic [DATA_W-1:0] ld_data
);
  logic run, tick, start;
  logic r_sk, r_do;
  logic s_cs, s_sk, s_do;

  assign start = cfg_we && cfg_read && !busy;

  srom_tick #(.DIV(DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(run), .tick(tick)
  );

  srom_regs u_regs (
    .clk(clk), .rst_n(rst_n), .we(cfg_we),
    .d_en(cfg_port_en), .d_cs(cfg_cs), .d_sk(cfg_sk), .d_do(cfg_do),
    .q_en(port_en), .q_cs(cs_bit), .q_sk(r_sk), .q_do(r_do)
  );

  srom_seq #(.NUM_WORDS(NUM_WORDS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .detect(rom_detect),
    .ser_di(rom_di), .tick(tick), .run(run), .busy(busy),
    .seq_cs(s_cs), .seq_sk(s_sk), .seq_do(s_do), .valid(checksum_ok),
    .ld_we(ld_we), .ld_addr(ld_addr), .ld_data(ld_data)
  );

  srom_pinmux u_mux (
    .busy(busy), .r_en(port_en), .r_cs(cs_bit), .r_sk(r_sk), .r_do(r_do),
    .led_sk(led_sk), .led_do(led_do), .s_cs(s_cs), .s_sk(s_sk), .s_do(s_do),
    .p_cs(rom_cs), .p_sk(rom_sk), .p_do(rom_do)
  );

  AST_CS_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !port_en) |-> !rom_cs); // R3
  AST_REQ_LAUNCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cfg_we && cfg_read) |=> busy); // R8
endmodule

// File: tb/sim_srom_port.sv
module sim_srom_port;
  localparam int DIV = 2;
  localparam int NW  = 8;
  localparam int AW  = 6;
  localparam int DW  = 16;
  localparam int WL  = 26 * 2 * DIV;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, cfg_we, cfg_port_en, cfg_cs, cfg_sk, cfg_do, cfg_read;
  logic led_sk, led_do, rom_detect, rom_di;
  logic rom_cs, rom_sk, rom_do, port_en, cs_bit, busy, checksum_ok, ld_we;
  logic [AW-1:0] ld_addr;
  logic [DW-1:0] ld_data;

  srom_port #(.DIV(DIV), .NUM_WORDS(NW), .ADDR_W(AW), .DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_port_en(cfg_port_en),
    .cfg_cs(cfg_cs), .cfg_sk(cfg_sk), .cfg_do(cfg_do), .cfg_read(cfg_read),
    .led_sk(led_sk), .led_do(led_do), .rom_detect(rom_detect), .rom_di(rom_di),
    .rom_cs(rom_cs), .rom_sk(rom_sk), .rom_do(rom_do), .port_en(port_en),
    .cs_bit(cs_bit), .busy(busy), .checksum_ok(checksum_ok), .ld_we(ld_we),
    .ld_addr(ld_addr), .ld_data(ld_data)
  );

  logic [15:0] mem [NW];
  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  // behavioural reference: 0 idle, 1 launch, 2 reading
  int   m_state, m_t;
  logic m_absent, m_valid, m_en, m_cs, m_sk, m_do;
  logic e_cs, e_sk, e_do, e_ld, e_di;
  int   e_w;

  assign rom_di = e_di;

  function automatic logic [7:0] mem_sum();
    int s = 0;
    for (int i = 0; i < NW; i++) s += mem[i][15:8] + mem[i][7:0];
    return 8'(s);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act,
                     input logic [31:0] exp, input string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state <= 1; m_t <= 0; m_absent <= 1'b0; m_valid <= 1'b0;
      m_en <= 1'b0; m_cs <= 1'b0; m_sk <= 1'b0; m_do <= 1'b0;
    end else begin
      if (cfg_we) begin
        m_en <= cfg_port_en; m_cs <= cfg_cs; m_sk <= cfg_sk; m_do <= cfg_do;
      end
      case (m_state)
        0: if (cfg_we && cfg_read) m_state <= 1;
        1: begin m_t <= 0; m_absent <= !rom_detect; m_state <= 2; end
        default: begin
          if (m_absent && m_t == 4 * DIV - 1) begin
            m_state <= 0; m_valid <= 1'b0;
          end else if (!m_absent && m_t == NW * WL - 1) begin
            m_state <= 0; m_valid <= (mem_sum() == 8'hFF);
          end else begin
            m_t <= m_t + 1;
          end
        end
      endcase
    end
  end

  always_comb begin
    int r, sl, ph;
    logic [8:0] cmd;
    e_cs = 1'b0; e_sk = 1'b0; e_do = 1'b0; e_ld = 1'b0; e_di = 1'b0; e_w = 0;
    r = 0; sl = 0; ph = 0; cmd = '0;
    if (m_state == 2) begin
      r   = m_t % WL;
      sl  = r / (2 * DIV);
      ph  = (r / DIV) % 2;
      e_w = (m_t / WL) % NW;
      cmd = {3'b110, 6'(e_w)};
      e_cs = (sl < 25);
      e_sk = e_cs && (ph == 1);
      e_do = (sl < 9) ? cmd[8 - sl] : 1'b0;
      e_di = (!m_absent && sl >= 9 && sl < 25) ? mem[e_w][15 - (sl - 9)] : 1'b0;
      e_ld = !m_absent && (r == 25 * 2 * DIV);
    end else if (m_state == 0) begin
      e_cs = m_en ? m_cs : 1'b0;
      e_sk = m_en ? m_sk : led_sk;
      e_do = m_en ? m_do : led_do;
    end
  end

  // compare with the reference on every cycle
  always @(negedge clk) begin
    if (rst_n) begin
      string tag;
      tag = (m_state != 0) ? "R4" : (m_en ? "R2" : "R3");
      chk(tag, 32'(rom_cs), 32'(e_cs), "rom_cs");
      chk(tag, 32'(rom_sk), 32'(e_sk), "rom_sk");
      chk(tag, 32'(rom_do), 32'(e_do), "rom_do");
      chk("R8", 32'(busy), 32'(m_state != 0), "busy");
      chk("R7", 32'(checksum_ok), 32'(m_valid), "checksum_ok");
      chk("R5", 32'(ld_we), 32'(e_ld), "ld_we");
      if (e_ld) begin
        chk("R5", 32'(ld_addr), 32'(e_w), "ld_addr");
        chk("R5", 32'(ld_data), 32'(mem[e_w]), "ld_data");
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired, busy=%0b expected 0", busy);
      finish_run();
    end
  end

  task automatic wr(input logic en, input logic cs, input logic sk,
                    input logic dout, input logic rd);
    @(posedge clk); #1;
    cfg_we = 1'b1; cfg_port_en = en; cfg_cs = cs; cfg_sk = sk;
    cfg_do = dout; cfg_read = rd;
    @(posedge clk); #1;
    cfg_we = 1'b0; cfg_read = 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (busy);
  endtask

  task automatic make_pass();
    int s = 0;
    for (int i = 0; i < NW - 1; i++) s += mem[i][15:8] + mem[i][7:0];
    mem[NW-1] = {8'h00, 8'(8'hFF - 8'(s))};
  endtask

  initial begin
    int c0, pulses, prev, lds;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_port_en = 1'b0; cfg_cs = 1'b0;
    cfg_sk = 1'b0; cfg_do = 1'b0; cfg_read = 1'b0;
    led_sk = 1'b0; led_do = 1'b0; rom_detect = 1'b1;
    mem[0] = 16'h1234; mem[1] = 16'hA55A; mem[2] = 16'h0F0F; mem[3] = 16'h8001;
    mem[4] = 16'h3C3C; mem[5] = 16'h7E00; mem[6] = 16'hC0DE; mem[7] = 16'h0000;
    make_pass();
    repeat (3) @(posedge clk);
    #1;
    chk("R1", 32'(port_en), 0, "port_en in reset");
    chk("R1", 32'(cs_bit), 0, "cs_bit in reset");
    chk("R1", 32'(checksum_ok), 0, "checksum_ok in reset");
    chk("R1", 32'(busy), 1, "busy in reset");
    rst_n = 1'b1;

    wait_idle();
    chk("R7", 32'(checksum_ok), 1, "auto read with good sum");

    // disabled: LED signals shown, select bit blocked
    led_sk = 1'b1; led_do = 1'b0;
    wr(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R3", 32'(rom_cs), 0, "cs while disabled");
    chk("R3", 32'(rom_sk), 1, "sk from led");
    chk("R3", 32'(rom_do), 0, "do from led");
    led_sk = 1'b0; led_do = 1'b1; #1;
    chk("R3", 32'(rom_sk), 0, "sk from led toggled");
    chk("R3", 32'(rom_do), 1, "do from led toggled");

    // bit-bang patterns
    wr(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R2", {29'd0, rom_cs, rom_sk, rom_do}, 32'b101, "pins after write");
    wr(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    chk("R2", {29'd0, rom_cs, rom_sk, rom_do}, 32'b010, "pins after write");
    wr(1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    chk("R2", {29'd0, rom_cs, rom_sk, rom_do}, 32'b111, "pins after write");

    // bad checksum, request with port disabled, writes during the read
    mem[3] = mem[3] ^ 16'h0100;
    wr(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    c0 = cyc;
    chk("R8", 32'(busy), 1, "busy after request while disabled");
    repeat (60) @(posedge clk);
    wr(1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
    wait_idle();
    chk("R8", 32'(cyc - c0), 32'(1 + NW * WL), "busy length");
    chk("R7", 32'(checksum_ok), 0, "bad sum clears flag");
    chk("R9", {29'd0, rom_cs, rom_sk, rom_do}, 32'b110, "bits written mid-read take over");

    mem[3] = mem[3] ^ 16'h0100;
    wr(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    wait_idle();
    chk("R7", 32'(checksum_ok), 1, "good sum sets flag");

    // no ROM fitted
    rom_detect = 1'b0;
    wr(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    c0 = cyc; pulses = 0; prev = 0; lds = 0;
    do begin
      @(negedge clk);
      if (rom_sk && prev == 0) pulses++;
      prev = rom_sk;
      if (ld_we) lds++;
    end while (busy);
    chk("R6", 32'(pulses), 2, "clock pulses on abort");
    chk("R6", 32'(cyc - c0), 32'(1 + 4 * DIV), "abort length");
    chk("R6", 32'(lds), 0, "no words on abort");
    chk("R6", 32'(checksum_ok), 0, "flag cleared on abort");
    rom_detect = 1'b1;

    repeat (4) @(posedge clk);
    finish_run();
  end
endmodule